// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block brings a single switchable power island up and down in hardware when software tells it to. On a power-up command it closes the island's power switch at the gentlest inrush-current step and, if the island does not report power-good within its observation window, moves to the next stronger step, up to the fourth. Once power-good is seen it removes electrical isolation, asks the island's memories to run repair, waits for the repair to finish, and finally removes functional isolation. On a power-down command it reverses the isolation and switch controls in strict order.

When a step fails, the block undoes exactly the steps it has already taken and raises an error flag. A ramp that never reaches power-good drops the switch. A repair that never completes restores electrical isolation and then drops the switch. Software drives the block through one 32-bit control and status word. Writes to that word are guarded by a key in the top byte. All time windows are counted in clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset every control output is low, the inrush code is 0, busy and error are low, and the status word reads 0 apart from the live power-good (bit 1) and repair-done (bit 4) inputs.
- R2: A write changes nothing unless bits 31:24 equal 8'h5A. A write with any other key leaves the enable bit and the outputs untouched and starts no sequence.
- R3: A keyed write stores bit 12 as the enable bit, which reads back at bit 12. With bit 12 set, bit 0 = 1 requests power-up and bit 0 = 0 requests power-down. With bit 12 clear, no sequence starts.
- R4: Power-up closes the switch with inrush code 0 in the cycle after the accepting edge. Each code is watched for 3*CYC_PER_US cycles. If power-good is absent for the whole window, the code steps up by one. The first code that gives power-good is kept, and the code reads back at bits 14:13.
- R5: If power-good is still absent when the window for code 3 ends, the switch opens, the code returns to 0 and the error flag (bit 17) is set.
- R6: Once power-good is seen, electrical isolation is released (bit 2) one cycle before the repair request (bit 3) is raised. When repair-done arrives, the repair request drops and functional isolation is released (bit 5) in the same cycle. Functional release never occurs without electrical release, and electrical release never occurs without the switch.
- R7: If repair-done does not arrive within CYC_PER_US cycles, the repair request drops and electrical isolation is restored. One cycle later the switch opens, the inrush code returns to 0 and the error flag is set.
- R8: A power-up request while the switch is already closed starts nothing, leaves busy low and leaves the error flag low.
- R9: Power-down applies functional isolation, then electrical isolation, then opens the switch, on three consecutive cycles. A power-down request while the switch is open starts nothing.
- R10: Busy (bit 16 and busy_o) is high while any sequence runs. Commands written while busy are ignored.
- R11: The error flag stays set until the next accepted command that starts a sequence, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data including key byte |
| reg_rdata_o | output | 32 | Status word |
| pwr_good_i | input | 1 | Island supply reports good |
| repair_done_i | input | 1 | Memory repair finished |
| sw_en_o | output | 1 | Power switch enable |
| inrush_o | output | 2 | Inrush current limit code |
| elec_rel_o | output | 1 | Electrical isolation released |
| func_rel_o | output | 1 | Functional isolation released |
| repair_req_o | output | 1 | Memory repair request |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Last sequence timed out |

## Verification
The bench sweeps the code at which the modelled island first reports power-good, from the first step to never. A design that ramps past the first good code, or steps after the wrong number of cycles, shows up as a wrong kept code or a wrong step time. The repair-done model can be held off to force the repair timeout. A design that skips restoring isolation, or leaves the inrush code set, then shows the wrong bits after the unwind. Directed cases try wrong keys, a cleared enable bit, repeated power-up, power-down while already off and commands during a ramp. A design that honours any of these would change the switch or the error state when it must not.

// File: rtl/pis_pkg.sv
// Shared types and field positions for the power island sequencer.
// Assumes a 32-bit control word with the key in the top byte.
package pis_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_REP_REQ,
        ST_REP_WAIT,
        ST_UNWIND_PWR,
        ST_OFF_ELEC,
        ST_OFF_SW
    } pis_state_e;

    localparam logic [7:0] PIS_KEY     = 8'h5A;
    localparam int         B_PWRUP     = 0;
    localparam int         B_PGOOD     = 1;
    localparam int         B_ELEC      = 2;
    localparam int         B_REPREQ    = 3;
    localparam int         B_REPDONE   = 4;
    localparam int         B_FUNC      = 5;
    localparam int         B_ENABLE    = 12;
    localparam int         B_INRUSH_LO = 13;
    localparam int         B_BUSY      = 16;
    localparam int         B_ERR       = 17;
endpackage

// File: rtl/pis_key_gate.sv
// Key check on control writes. It holds the enable bit and turns accepted
// writes into single-cycle power-up or power-down command pulses.
// Assumes the write strobe is one cycle per write.
module pis_key_gate
    import pis_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    output logic        en_q_o,
    output logic        cmd_on_o,
    output logic        cmd_off_o
);
    logic key_ok;

    // Purpose: decide whether this write carries the key.
    always_comb key_ok = wr_i && (wdata_i[31:24] == PIS_KEY);

    // Purpose: store the enable bit from accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q_o <= 1'b0;
        else if (key_ok) en_q_o <= wdata_i[B_ENABLE];
    end

    // Purpose: turn accepted, enabled writes into command pulses.
    always_comb begin
        cmd_on_o  = key_ok && wdata_i[B_ENABLE] &&  wdata_i[B_PWRUP];
        cmd_off_o = key_ok && wdata_i[B_ENABLE] && !wdata_i[B_PWRUP];
    end

    // R2: a write with a wrong key leaves the enable bit alone
    a_r2_bad_key_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[31:24] != PIS_KEY) |=> $stable(en_q_o));
endmodule

// File: rtl/pis_window_timer.sv
// Down-counter for timeout windows. A load sets the count, and it then
// decrements to zero and holds there. zero_o flags an expired window.
module pis_window_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    // Purpose: load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load_i)           cnt <= load_val_i;
        else if (cnt != '0)        cnt <= cnt - 1'b1;
    end

    // Purpose: report expiry.
    always_comb zero_o = (cnt == '0);
endmodule

// File: rtl/pis_seq_fsm.sv
// Sequencer for power-up (inrush ramp, isolation release, memory repair)
// and power-down (isolation, then switch open), with unwind on timeout.
// Assumes command pulses are one cycle wide and that they are ignored
// while a sequence runs.
module pis_seq_fsm
    import pis_pkg::*;
#(
    parameter int CYC_PER_US = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_on_i,
    input  logic       cmd_off_i,
    input  logic       pwr_good_i,
    input  logic       repair_done_i,
    output logic       sw_en_o,
    output logic [1:0] inrush_o,
    output logic       elec_rel_o,
    output logic       func_rel_o,
    output logic       repair_req_o,
    output logic       busy_o,
    output logic       err_o
);
    localparam int RAMP_CYC = 3 * CYC_PER_US;
    localparam int REP_CYC  = CYC_PER_US;
    localparam int TW       = $clog2(RAMP_CYC + 1);
    localparam logic [TW-1:0] RAMP_LOAD = TW'(RAMP_CYC - 1);
    localparam logic [TW-1:0] REP_LOAD  = TW'(REP_CYC - 1);
    localparam logic [1:0]    TOP_CODE  = 2'd3;

    pis_state_e    state;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    pis_window_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // Purpose: decide when the window timer restarts and with what length.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = RAMP_LOAD;
        if (state == ST_IDLE && cmd_on_i && !sw_en_o) begin
            tmr_load = 1'b1;
        end else if (state == ST_RAMP && !pwr_good_i && tmr_zero && inrush_o != TOP_CODE) begin
            tmr_load = 1'b1;
        end else if (state == ST_REP_REQ) begin
            tmr_load = 1'b1;
            tmr_val  = REP_LOAD;
        end
    end

    // Purpose: step the sequence and drive the registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            sw_en_o      <= 1'b0;
            inrush_o     <= 2'd0;
            elec_rel_o   <= 1'b0;
            func_rel_o   <= 1'b0;
            repair_req_o <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_on_i && !sw_en_o) begin
                        sw_en_o  <= 1'b1;
                        inrush_o <= 2'd0;
                        err_o    <= 1'b0;
                        state    <= ST_RAMP;
                    end else if (cmd_off_i && sw_en_o) begin
                        func_rel_o <= 1'b0;
                        err_o      <= 1'b0;
                        state      <= ST_OFF_ELEC;
                    end
                end
                ST_RAMP: begin
                    if (pwr_good_i) begin
                        elec_rel_o <= 1'b1;
                        state      <= ST_REP_REQ;
                    end else if (tmr_zero) begin
                        if (inrush_o == TOP_CODE) begin
                            sw_en_o  <= 1'b0;
                            inrush_o <= 2'd0;
                            err_o    <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            inrush_o <= inrush_o + 2'd1;
                        end
                    end
                end
                ST_REP_REQ: begin
                    repair_req_o <= 1'b1;
                    state        <= ST_REP_WAIT;
                end
                ST_REP_WAIT: begin
                    if (repair_done_i) begin
                        repair_req_o <= 1'b0;
                        func_rel_o   <= 1'b1;
                        state        <= ST_IDLE;
                    end else if (tmr_zero) begin
                        repair_req_o <= 1'b0;
                        elec_rel_o   <= 1'b0;
                        state        <= ST_UNWIND_PWR;
                    end
                end
                ST_UNWIND_PWR: begin
                    sw_en_o  <= 1'b0;
                    inrush_o <= 2'd0;
                    err_o    <= 1'b1;
                    state    <= ST_IDLE;
                end
                ST_OFF_ELEC: begin
                    elec_rel_o <= 1'b0;
                    state      <= ST_OFF_SW;
                end
                ST_OFF_SW: begin
                    sw_en_o <= 1'b0;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: expose sequence activity.
    always_comb busy_o = (state != ST_IDLE);

    // R6: functional release only while electrical isolation is released
    a_r6_func_needs_elec: assert property (@(posedge clk) disable iff (!rst_n)
        func_rel_o |-> elec_rel_o);
    // R6: electrical release only with the switch closed
    a_r6_elec_needs_switch: assert property (@(posedge clk) disable iff (!rst_n)
        elec_rel_o |-> sw_en_o);
    // R6: repair is requested only after electrical release
    a_r6_repair_needs_elec: assert property (@(posedge clk) disable iff (!rst_n)
        repair_req_o |-> elec_rel_o);
    // R4: an expired window without power-good steps the code by one
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && tmr_zero && !pwr_good_i && inrush_o != TOP_CODE)
        |=> (inrush_o == $past(inrush_o) + 2'd1));
    // R5 and R7: a raised error leaves the island fully off
    a_r5_fail_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!sw_en_o && inrush_o == 2'd0 && !elec_rel_o));
    // R10: commands arriving while busy leave the error flag unchanged
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state == ST_OFF_SW && (cmd_on_i || cmd_off_i)) |=> $stable(err_o));
endmodule

// File: rtl/pwr_island_seq.sv
// Top of the power island sequencer. It joins the key gate and the
// sequencer and assembles the status word. Assumes pwr_good_i and
// repair_done_i are already synchronous to clk.
module pwr_island_seq
    import pis_pkg::*;
#(
    parameter int CYC_PER_US = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        pwr_good_i,
    input  logic        repair_done_i,
    output logic        sw_en_o,
    output logic [1:0]  inrush_o,
    output logic        elec_rel_o,
    output logic        func_rel_o,
    output logic        repair_req_o,
    output logic        busy_o,
    output logic        err_o
);
    logic en_q;
    logic cmd_on;
    logic cmd_off;

    pis_key_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .en_q_o    (en_q),
        .cmd_on_o  (cmd_on),
        .cmd_off_o (cmd_off)
    );

    pis_seq_fsm #(.CYC_PER_US(CYC_PER_US)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_on_i      (cmd_on),
        .cmd_off_i     (cmd_off),
        .pwr_good_i    (pwr_good_i),
        .repair_done_i (repair_done_i),
        .sw_en_o       (sw_en_o),
        .inrush_o      (inrush_o),
        .elec_rel_o    (elec_rel_o),
        .func_rel_o    (func_rel_o),
        .repair_req_o  (repair_req_o),
        .busy_o        (busy_o),
        .err_o         (err_o)
    );

    // Purpose: assemble the status word from state and live inputs.
    always_comb begin
        reg_rdata_o                           = '0;
        reg_rdata_o[B_PWRUP]                  = sw_en_o;
        reg_rdata_o[B_PGOOD]                  = pwr_good_i;
        reg_rdata_o[B_ELEC]                   = elec_rel_o;
        reg_rdata_o[B_REPREQ]                 = repair_req_o;
        reg_rdata_o[B_REPDONE]                = repair_done_i;
        reg_rdata_o[B_FUNC]                   = func_rel_o;
        reg_rdata_o[B_ENABLE]                 = en_q;
        reg_rdata_o[B_INRUSH_LO+1:B_INRUSH_LO] = inrush_o;
        reg_rdata_o[B_BUSY]                   = busy_o;
        reg_rdata_o[B_ERR]                    = err_o;
    end
endmodule

// File: tb/pwr_island_seq_tb_top.sv
module pwr_island_seq_tb_top;
    localparam int CPU = 4;
    localparam int RAMP_W = 3 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sw_en, elec, func, rreq, busy, err;
    logic [1:0]  inrush;
    logic        pg, rdone;
    int          need_code = 0;   // 4 means never good
    logic        rep_ok = 1'b1;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    // island models
    assign pg    = sw_en && (int'(inrush) >= need_code);
    assign rdone = rreq && rep_ok;

    pwr_island_seq #(.CYC_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .pwr_good_i(pg), .repair_done_i(rdone),
        .sw_en_o(sw_en), .inrush_o(inrush), .elec_rel_o(elec),
        .func_rel_o(func), .repair_req_o(rreq), .busy_o(busy), .err_o(err)
    );

    // need, rep_ok, exp_inrush, exp_sw, exp_err, exp_func
    typedef struct packed {
        logic [2:0] need;
        logic       rok;
        logic [1:0] inr;
        logic       sw;
        logic       er;
        logic       fn;
    } vec_t;
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1},
        '{3'd1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1},
        '{3'd3, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1},
        '{3'd4, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0},
        '{3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        '{3'd2, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && busy; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        need_code = 4;
        repeat (3) @(negedge clk);
        // R1 reset state (need 4 keeps pg low)
        chk("R1", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {26'd0, sw_en, elec, func, rreq, busy, err}, 32'h0);

        // vector table: R4 R5 R6 R7
        foreach (VECS[k]) begin
            wr_reg(32'h5A00_1000);         // power down if up
            wait_idle();
            need_code = int'(VECS[k].need);
            rep_ok    = VECS[k].rok;
            wr_reg(32'h5A00_1001);
            wait_idle();
            chk("R4 R5 R7 inrush", {30'd0, inrush}, {30'd0, VECS[k].inr});
            chk("R5 R7 switch", {31'd0, sw_en}, {31'd0, VECS[k].sw});
            chk("R11 error", {31'd0, err}, {31'd0, VECS[k].er});
            chk("R6 func release", {31'd0, func}, {31'd0, VECS[k].fn});
            chk("R11 readback", rdata[17:13],
                {VECS[k].er, busy, 1'b0, VECS[k].inr});
        end

        // R6 exact order with good at code 0
        wr_reg(32'h5A00_1000); wait_idle();
        need_code = 0; rep_ok = 1'b1;
        wr_reg(32'h5A00_1001);
        chk("R6 step0", {29'd0, sw_en, elec, rreq}, {29'd0, 3'b100});
        @(negedge clk);
        chk("R6 step1", {29'd0, elec, rreq, func}, {29'd0, 3'b100});
        @(negedge clk);
        chk("R6 step2", {29'd0, elec, rreq, func}, {29'd0, 3'b110});
        @(negedge clk);
        chk("R6 step3", {29'd0, rreq, func, busy}, {29'd0, 3'b010});

        // R8 repeat power-up ignored
        wr_reg(32'h5A00_1001);
        chk("R8 no busy", {31'd0, busy}, 32'd0);
        chk("R8 state kept", {28'd0, sw_en, elec, func, err}, {28'd0, 4'b1110});

        // R9 power-down order
        wr_reg(32'h5A00_1000);
        chk("R9 step0", {29'd0, sw_en, elec, func}, {29'd0, 3'b110});
        @(negedge clk);
        chk("R9 step1", {29'd0, sw_en, elec, func}, {29'd0, 3'b100});
        @(negedge clk);
        chk("R9 step2", {29'd0, sw_en, elec, busy}, {29'd0, 3'b000});
        wr_reg(32'h5A00_1000);
        chk("R9 off when off", {30'd0, busy, sw_en}, 32'd0);

        // R2 wrong key
        wr_reg(32'h5B00_1001);
        @(negedge clk);
        chk("R2 bad key", {29'd0, busy, sw_en, rdata[12]}, {29'd0, 3'b001});
        wr_reg(32'h0000_0000);
        chk("R2 bad key enable", {31'd0, rdata[12]}, 32'd1);

        // R3 enable clear blocks command
        wr_reg(32'h5A00_0001);
        @(negedge clk);
        chk("R3 enable clear", {29'd0, busy, sw_en, rdata[12]}, {29'd0, 3'b000});

        // R4 step timing, R10 busy ignore
        need_code = 4;
        wr_reg(32'h5A00_1001);
        chk("R10 busy", {31'd0, rdata[16]}, 32'd1);
        repeat (RAMP_W - 1) @(negedge clk);
        chk("R4 before step", {30'd0, inrush}, {30'd0, 2'd0});
        @(negedge clk);
        chk("R4 after step", {30'd0, inrush}, {30'd0, 2'd1});
        wr_reg(32'h5A00_1000);             // off during ramp: ignored
        chk("R10 ignored", {30'd0, busy, sw_en}, {30'd0, 2'b11});
        wait_idle();
        chk("R5 fail", {29'd0, sw_en, err, busy}, {29'd0, 3'b010});

        // R11 error cleared by the next accepted command
        need_code = 0;
        wr_reg(32'h5A00_1001);
        chk("R11 err cleared", {31'd0, err}, 32'd0);
        wait_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule